// File: doc/BRIEF.md
# Thread-Block Admission and Occupancy Controller

This block sits in front of one streaming multiprocessor and decides whether a newly launched thread block may become resident there. A request carries the number of threads in the block and the registers each thread needs. The controller turns that into a footprint: one block slot, a whole number of warp slots, thread slots, and registers. It admits the block only when every per-multiprocessor limit still holds once the footprint is added. A block is always admitted whole or not at all.

An admitted block receives the lowest free slot index, and the controller remembers that block's footprint under the slot. A completion pulse that names the slot returns the footprint to the pool, so a later request can use it. Running totals of resident blocks, warps, thread slots and registers are visible at all times. The resident warp count is the occupancy figure, with 64 meaning full.

Top module: `blk_admit_ctrl`

## Requirements
- R1: `req_ready` is high from the first clock edge after reset onward. Every cycle with `req_valid` and `req_ready` both high produces `rsp_valid` high in the next cycle. `rsp_valid` is low in any cycle that follows a cycle with no handshake.
- R2: A request for 0 threads, or for more than 1024 threads, is rejected with cause code 1 and changes no total.
- R3: A block uses ceil(threads/32) warp slots. `occ_warps` is the sum over resident blocks. Four 512-thread blocks give 64, thirty-two 32-thread blocks give 32, two 768-thread blocks give 48, and a 33-thread block counts as 2 warps.
- R4: At most 32 blocks are resident at once. A legal request made while all 32 slots are held is rejected with cause code 2.
- R5: A request is rejected with cause code 3 when its warps would take the resident total above 64, or its threads would take the thread total above 2048. A request that lands exactly on either limit is accepted.
- R6: A block needs registers-per-thread times thread count registers. It is rejected with cause code 4 when that exceeds 65536 minus the registers already held. Reaching exactly 65536 is allowed.
- R7: An accepted request reports cause code 0. When several limits fail at once, the reported cause is the lowest non-zero code that applies, in the order 1, 2, 3, 4.
- R8: An accepted block is given the lowest-numbered free slot, which is reported on `rsp_slot`. A rejection reports slot 0.
- R9: `done_valid` with a held slot in `done_slot` removes that block's blocks, warps, threads and registers from the totals on the next edge, and the slot becomes free for reuse.
- R10: `done_valid` naming a slot that is not held changes no total. It drives `err_release` high for exactly the next cycle.
- R11: When a request and a valid completion arrive in the same cycle, the admission decision uses the totals from before that completion.
- R12: After reset all totals read zero, and `rsp_valid` and `err_release` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Controller can take a request |
| req_threads | input | 11 | Threads in the requested block |
| req_regs | input | 8 | Registers per thread |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_accept | output | 1 | Block admitted |
| rsp_slot | output | 5 | Slot given to the admitted block |
| rsp_cause | output | 3 | 0 ok, 1 bad size, 2 no block slot, 3 no warp/thread room, 4 no registers |
| done_valid | input | 1 | Completion pulse |
| done_slot | input | 5 | Slot of the finished block |
| err_release | output | 1 | Previous completion named a free slot |
| occ_warps | output | 7 | Resident warps (occupancy, 0 to 64) |
| res_blocks | output | 6 | Resident blocks |
| res_threads | output | 12 | Resident thread slots in use |
| res_regs | output | 17 | Registers held |

## Verification
The bench builds the block with its default parameters: 32 block slots, 64 warps, 2048 threads, a 65536-register budget, 32-thread warps and 1024 threads per block at most. With a power-of-two warp size, the shift-based rounding variant is the one built. These values let short request sequences reach each limit exactly and just beyond it. The three occupancy cases (4×512, 32×32, 2×768) each fill a different limit. The register budget is reached at exactly 65536 with four 512-thread blocks at 32 registers per thread. Filling all 32 slots exposes the block-count limit, slot reuse after release, and the same-cycle request and completion case.

// File: rtl/adm_pkg.sv
package adm_pkg;
   localparam int unsigned DEF_MAX_BLOCKS     = 32;
   localparam int unsigned DEF_MAX_WARPS      = 64;
   localparam int unsigned DEF_MAX_THREADS    = 2048;
   localparam int unsigned DEF_REG_BUDGET     = 65536;
   localparam int unsigned DEF_WARP_SIZE      = 32;
   localparam int unsigned DEF_MAX_BLK_THR    = 1024;
   localparam int unsigned DEF_RPT_W          = 8;

   typedef enum logic [2:0] {
      CAUSE_OK       = 3'd0,
      CAUSE_BAD_SIZE = 3'd1,
      CAUSE_NO_BLOCK = 3'd2,
      CAUSE_NO_WARP  = 3'd3,
      CAUSE_NO_REGS  = 3'd4
   } adm_cause_e;
endpackage

// File: rtl/adm_demand.sv
// Turns a launch request into its resource footprint.
module adm_demand #(
   parameter int unsigned WARP_SIZE       = 32,
   parameter int unsigned MAX_BLK_THREADS = 1024,
   parameter int unsigned BLKTHR_W        = 11,
   parameter int unsigned RPT_W           = 8,
   localparam int unsigned DREG_W         = BLKTHR_W + RPT_W
) (
   input  logic [BLKTHR_W-1:0] threads,
   input  logic [RPT_W-1:0]    regs_pt,
   output logic                legal,
   output logic [BLKTHR_W-1:0] warps,
   output logic [DREG_W-1:0]   regs
);
   localparam logic [BLKTHR_W-1:0] THR_LIM = BLKTHR_W'(MAX_BLK_THREADS);
   localparam int unsigned SH = $clog2(WARP_SIZE);

   assign legal = (threads != '0) && (threads <= THR_LIM);
   assign regs  = DREG_W'(threads) * DREG_W'(regs_pt);

   // Partial warps occupy a whole warp slot: round up.
   if ((1 << SH) == WARP_SIZE) begin : g_pow2
      assign warps = (threads >> SH) + BLKTHR_W'(|threads[SH-1:0]);
   end else begin : g_div
      localparam logic [BLKTHR_W-1:0] WS = BLKTHR_W'(WARP_SIZE);
      assign warps = (threads / WS) + BLKTHR_W'((threads % WS) != '0);
   end
endmodule

// File: rtl/adm_slots.sv
// Per-slot footprint store with lowest-free-slot selection.
module adm_slots #(
   parameter int unsigned MAX_BLOCKS = 32,
   parameter int unsigned SLOT_W     = 5,
   parameter int unsigned WRP_W      = 7,
   parameter int unsigned THR_W      = 11,
   parameter int unsigned REG_W      = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [WRP_W-1:0]  alloc_warps,
   input  logic [THR_W-1:0]  alloc_threads,
   input  logic [REG_W-1:0]  alloc_regs,
   output logic              free_any,
   output logic [SLOT_W-1:0] free_idx,
   input  logic              rel_en,
   input  logic [SLOT_W-1:0] rel_slot,
   output logic              rel_hit,
   output logic [WRP_W-1:0]  rel_warps,
   output logic [THR_W-1:0]  rel_threads,
   output logic [REG_W-1:0]  rel_regs
);
   logic [MAX_BLOCKS-1:0] busy;
   logic [WRP_W-1:0]      warp_q [MAX_BLOCKS];
   logic [THR_W-1:0]      thr_q  [MAX_BLOCKS];
   logic [REG_W-1:0]      reg_q  [MAX_BLOCKS];
   logic                  slot_in_range;

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = MAX_BLOCKS - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            free_any = 1'b1;
            free_idx = SLOT_W'(i);
         end
      end
   end

   assign slot_in_range = 32'(rel_slot) < MAX_BLOCKS;
   assign rel_hit       = slot_in_range && busy[rel_slot];
   assign rel_warps     = warp_q[rel_slot];
   assign rel_threads   = thr_q[rel_slot];
   assign rel_regs      = reg_q[rel_slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= '0;
         for (int i = 0; i < MAX_BLOCKS; i++) begin
            warp_q[i] <= '0;
            thr_q[i]  <= '0;
            reg_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < MAX_BLOCKS; i++) begin
            if (alloc_en && free_idx == SLOT_W'(i)) begin
               busy[i]   <= 1'b1;
               warp_q[i] <= alloc_warps;
               thr_q[i]  <= alloc_threads;
               reg_q[i]  <= alloc_regs;
            end else if (rel_en && rel_slot == SLOT_W'(i)) begin
               busy[i] <= 1'b0;
            end
         end
      end
   end

   // R8: the chosen slot is held after the allocating edge.
   p_alloc_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |=> busy[$past(free_idx)]);
   // R9: a released slot is free after the releasing edge.
   p_rel_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rel_en |=> !busy[$past(rel_slot)]);
endmodule

// File: rtl/adm_ledger.sv
// Running resident totals.
module adm_ledger #(
   parameter int unsigned MAX_BLOCKS  = 32,
   parameter int unsigned MAX_WARPS   = 64,
   parameter int unsigned MAX_THREADS = 2048,
   parameter int unsigned REG_BUDGET  = 65536,
   parameter int unsigned BLK_W       = 6,
   parameter int unsigned WRP_W       = 7,
   parameter int unsigned THR_W       = 12,
   parameter int unsigned REG_W       = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_en,
   input  logic [WRP_W-1:0] add_warps,
   input  logic [THR_W-1:0] add_threads,
   input  logic [REG_W-1:0] add_regs,
   input  logic             sub_en,
   input  logic [WRP_W-1:0] sub_warps,
   input  logic [THR_W-1:0] sub_threads,
   input  logic [REG_W-1:0] sub_regs,
   output logic [BLK_W-1:0] tot_blocks,
   output logic [WRP_W-1:0] tot_warps,
   output logic [THR_W-1:0] tot_threads,
   output logic [REG_W-1:0] tot_regs
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tot_blocks  <= '0;
         tot_warps   <= '0;
         tot_threads <= '0;
         tot_regs    <= '0;
      end else begin
         tot_blocks  <= tot_blocks + BLK_W'(add_en) - BLK_W'(sub_en);
         tot_warps   <= tot_warps + (add_en ? add_warps : '0)
                                  - (sub_en ? sub_warps : '0);
         tot_threads <= tot_threads + (add_en ? add_threads : '0)
                                    - (sub_en ? sub_threads : '0);
         tot_regs    <= tot_regs + (add_en ? add_regs : '0)
                                 - (sub_en ? sub_regs : '0);
      end
   end

   p_blk_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tot_blocks) <= MAX_BLOCKS);
   p_warp_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tot_warps) <= MAX_WARPS);
   p_thr_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tot_threads) <= MAX_THREADS);
   p_reg_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tot_regs) <= REG_BUDGET);
endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl
   import adm_pkg::*;
#(
   parameter int unsigned MAX_BLOCKS      = DEF_MAX_BLOCKS,
   parameter int unsigned MAX_WARPS       = DEF_MAX_WARPS,
   parameter int unsigned MAX_THREADS     = DEF_MAX_THREADS,
   parameter int unsigned REG_BUDGET      = DEF_REG_BUDGET,
   parameter int unsigned WARP_SIZE       = DEF_WARP_SIZE,
   parameter int unsigned MAX_BLK_THREADS = DEF_MAX_BLK_THR,
   parameter int unsigned RPT_W           = DEF_RPT_W,
   localparam int unsigned SLOT_W   = $clog2(MAX_BLOCKS),
   localparam int unsigned BLKTHR_W = $clog2(MAX_BLK_THREADS + 1),
   localparam int unsigned BLK_W    = $clog2(MAX_BLOCKS + 1),
   localparam int unsigned WRP_W    = $clog2(MAX_WARPS + 1),
   localparam int unsigned THR_W    = $clog2(MAX_THREADS + 1),
   localparam int unsigned REG_W    = $clog2(REG_BUDGET + 1),
   localparam int unsigned DREG_W   = BLKTHR_W + RPT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [BLKTHR_W-1:0] req_threads,
   input  logic [RPT_W-1:0]    req_regs,
   output logic                rsp_valid,
   output logic                rsp_accept,
   output logic [SLOT_W-1:0]   rsp_slot,
   output logic [2:0]          rsp_cause,
   input  logic                done_valid,
   input  logic [SLOT_W-1:0]   done_slot,
   output logic                err_release,
   output logic [WRP_W-1:0]    occ_warps,
   output logic [BLK_W-1:0]    res_blocks,
   output logic [THR_W-1:0]    res_threads,
   output logic [REG_W-1:0]    res_regs
);
   // Elaboration-time parameter checks.
   if (WARP_SIZE < 2) begin : g_chk_ws
      $error("WARP_SIZE must be at least 2");
   end
   if (MAX_BLOCKS < 2) begin : g_chk_blk
      $error("MAX_BLOCKS must be at least 2");
   end
   if (MAX_BLK_THREADS > MAX_THREADS) begin : g_chk_thr
      $error("a legal block must fit in the thread slots");
   end
   if (MAX_WARPS * WARP_SIZE < MAX_THREADS) begin : g_chk_wrp
      $error("warp slots cannot cover the thread slots");
   end

   logic                dem_legal;
   logic [BLKTHR_W-1:0] dem_warps;
   logic [DREG_W-1:0]   dem_regs;

   adm_demand #(
      .WARP_SIZE(WARP_SIZE), .MAX_BLK_THREADS(MAX_BLK_THREADS),
      .BLKTHR_W(BLKTHR_W), .RPT_W(RPT_W)
   ) u_demand (
      .threads(req_threads), .regs_pt(req_regs),
      .legal(dem_legal), .warps(dem_warps), .regs(dem_regs)
   );

   logic              fire, admit, rel_fire;
   logic              free_any, rel_hit;
   logic [SLOT_W-1:0] free_idx;
   logic [WRP_W-1:0]  rel_warps;
   logic [BLKTHR_W-1:0] rel_threads;
   logic [REG_W-1:0]  rel_regs;
   logic              fit_warps, fit_threads, fit_regs;
   adm_cause_e        cause;
   logic              ready_q;

   assign req_ready = ready_q;
   assign fire      = req_valid && ready_q;

   // Limits are judged against the totals before any same-cycle release.
   assign fit_warps   = 32'(occ_warps) + 32'(dem_warps) <= MAX_WARPS;
   assign fit_threads = 32'(res_threads) + 32'(req_threads) <= MAX_THREADS;
   assign fit_regs    = 32'(res_regs) + 32'(dem_regs) <= REG_BUDGET;

   always_comb begin
      if (!dem_legal)                     cause = CAUSE_BAD_SIZE;
      else if (!free_any)                 cause = CAUSE_NO_BLOCK;
      else if (!fit_warps || !fit_threads) cause = CAUSE_NO_WARP;
      else if (!fit_regs)                 cause = CAUSE_NO_REGS;
      else                                cause = CAUSE_OK;
   end

   assign admit    = fire && (cause == CAUSE_OK);
   assign rel_fire = done_valid && rel_hit;

   adm_slots #(
      .MAX_BLOCKS(MAX_BLOCKS), .SLOT_W(SLOT_W), .WRP_W(WRP_W),
      .THR_W(BLKTHR_W), .REG_W(REG_W)
   ) u_slots (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(admit), .alloc_warps(WRP_W'(dem_warps)),
      .alloc_threads(req_threads), .alloc_regs(REG_W'(dem_regs)),
      .free_any(free_any), .free_idx(free_idx),
      .rel_en(rel_fire), .rel_slot(done_slot), .rel_hit(rel_hit),
      .rel_warps(rel_warps), .rel_threads(rel_threads), .rel_regs(rel_regs)
   );

   adm_ledger #(
      .MAX_BLOCKS(MAX_BLOCKS), .MAX_WARPS(MAX_WARPS),
      .MAX_THREADS(MAX_THREADS), .REG_BUDGET(REG_BUDGET),
      .BLK_W(BLK_W), .WRP_W(WRP_W), .THR_W(THR_W), .REG_W(REG_W)
   ) u_ledger (
      .clk(clk), .rst_n(rst_n),
      .add_en(admit), .add_warps(WRP_W'(dem_warps)),
      .add_threads(THR_W'(req_threads)), .add_regs(REG_W'(dem_regs)),
      .sub_en(rel_fire), .sub_warps(rel_warps),
      .sub_threads(THR_W'(rel_threads)), .sub_regs(rel_regs),
      .tot_blocks(res_blocks), .tot_warps(occ_warps),
      .tot_threads(res_threads), .tot_regs(res_regs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q     <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_accept  <= 1'b0;
         rsp_slot    <= '0;
         rsp_cause   <= 3'd0;
         err_release <= 1'b0;
      end else begin
         ready_q     <= 1'b1;
         rsp_valid   <= fire;
         rsp_accept  <= admit;
         rsp_slot    <= admit ? free_idx : '0;
         rsp_cause   <= fire ? 3'(cause) : 3'd0;
         err_release <= done_valid && !rel_hit;
      end
   end

   // R1: one response per handshake, one cycle later.
   p_rsp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_valid);
   p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !rsp_valid);
   // R2: an illegal size is never admitted.
   p_bad_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (req_threads == '0 || 32'(req_threads) > MAX_BLK_THREADS)
      |=> rsp_valid && !rsp_accept && rsp_cause == 3'd1);
   // R10: a stray completion flags an error and leaves totals alone.
   p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && !rel_hit && !admit
      |=> err_release && $stable(occ_warps) && $stable(res_regs));
   // R11: a completion does not turn a full-slot request into an accept.
   p_no_early_reuse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !free_any |=> !rsp_accept);
endmodule

// File: tb/tb_blk_admit_ctrl.sv
`timescale 1ns/1ps
module tb_blk_admit_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [10:0] req_threads = '0;
   logic [7:0]  req_regs = '0;
   logic        rsp_valid, rsp_accept;
   logic [4:0]  rsp_slot;
   logic [2:0]  rsp_cause;
   logic        done_valid = 1'b0;
   logic [4:0]  done_slot = '0;
   logic        err_release;
   logic [6:0]  occ_warps;
   logic [5:0]  res_blocks;
   logic [11:0] res_threads;
   logic [16:0] res_regs;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   blk_admit_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_threads(req_threads), .req_regs(req_regs),
      .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
      .rsp_slot(rsp_slot), .rsp_cause(rsp_cause),
      .done_valid(done_valid), .done_slot(done_slot),
      .err_release(err_release), .occ_warps(occ_warps),
      .res_blocks(res_blocks), .res_threads(res_threads),
      .res_regs(res_regs)
   );

   typedef struct packed {
      logic        rel;
      logic [10:0] thr;
      logic [7:0]  arg;
      logic        acc;
      logic [4:0]  slot;
      logic [2:0]  cause;
      logic [6:0]  warps;
      logic [16:0] regs;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 11'd512,  8'd32, 1'b1, 5'd0, 3'd0, 7'd16, 17'd16384},
      '{1'b0, 11'd512,  8'd32, 1'b1, 5'd1, 3'd0, 7'd32, 17'd32768},
      '{1'b0, 11'd512,  8'd32, 1'b1, 5'd2, 3'd0, 7'd48, 17'd49152},
      '{1'b0, 11'd512,  8'd32, 1'b1, 5'd3, 3'd0, 7'd64, 17'd65536},
      '{1'b0, 11'd32,   8'd1,  1'b0, 5'd0, 3'd3, 7'd64, 17'd65536},
      '{1'b1, 11'd0,    8'd1,  1'b0, 5'd0, 3'd0, 7'd48, 17'd49152},
      '{1'b0, 11'd1025, 8'd1,  1'b0, 5'd0, 3'd1, 7'd48, 17'd49152},
      '{1'b0, 11'd33,   8'd1,  1'b1, 5'd1, 3'd0, 7'd50, 17'd49185},
      '{1'b1, 11'd0,    8'd0,  1'b0, 5'd0, 3'd0, 7'd34, 17'd32801},
      '{1'b1, 11'd0,    8'd2,  1'b0, 5'd0, 3'd0, 7'd18, 17'd16417},
      '{1'b1, 11'd0,    8'd3,  1'b0, 5'd0, 3'd0, 7'd2,  17'd33},
      '{1'b1, 11'd0,    8'd1,  1'b0, 5'd0, 3'd0, 7'd0,  17'd0},
      '{1'b0, 11'd768,  8'd64, 1'b1, 5'd0, 3'd0, 7'd24, 17'd49152},
      '{1'b0, 11'd768,  8'd64, 1'b0, 5'd0, 3'd4, 7'd24, 17'd49152},
      '{1'b0, 11'd768,  8'd21, 1'b1, 5'd1, 3'd0, 7'd48, 17'd65280},
      '{1'b0, 11'd768,  8'd0,  1'b0, 5'd0, 3'd3, 7'd48, 17'd65280},
      '{1'b0, 11'd256,  8'd0,  1'b1, 5'd2, 3'd0, 7'd56, 17'd65280},
      '{1'b0, 11'd256,  8'd0,  1'b1, 5'd3, 3'd0, 7'd64, 17'd65280},
      '{1'b1, 11'd0,    8'd0,  1'b0, 5'd0, 3'd0, 7'd40, 17'd16128},
      '{1'b1, 11'd0,    8'd1,  1'b0, 5'd0, 3'd0, 7'd16, 17'd0},
      '{1'b1, 11'd0,    8'd2,  1'b0, 5'd0, 3'd0, 7'd8,  17'd0},
      '{1'b1, 11'd0,    8'd3,  1'b0, 5'd0, 3'd0, 7'd0,  17'd0},
      '{1'b0, 11'd0,    8'd5,  1'b0, 5'd0, 3'd1, 7'd0,  17'd0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the falling edge after the next rise.
   task automatic drive(input logic v, input logic [10:0] thr,
                        input logic [7:0] rg, input logic dv,
                        input logic [4:0] ds);
      req_valid = v; req_threads = thr; req_regs = rg;
      done_valid = dv; done_slot = ds;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; done_valid = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state, R1 ready
      chk("R12 occ_warps", int'(occ_warps), 0);
      chk("R12 res_regs", int'(res_regs), 0);
      chk("R12 res_blocks", int'(res_blocks), 0);
      chk("R12 rsp_valid", int'(rsp_valid), 0);
      chk("R12 err_release", int'(err_release), 0);
      chk("R1 req_ready", int'(req_ready), 1);

      // Vector table: R2 R3 R5 R6 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         if (TBL[i].rel) begin
            drive(1'b0, 11'd0, 8'd0, 1'b1, TBL[i].arg[4:0]);
            chk($sformatf("R1 no rsp v%0d", i), int'(rsp_valid), 0);
            chk($sformatf("R9 warps v%0d", i), int'(occ_warps), int'(TBL[i].warps));
            chk($sformatf("R9 regs v%0d", i), int'(res_regs), int'(TBL[i].regs));
         end else begin
            drive(1'b1, TBL[i].thr, TBL[i].arg, 1'b0, 5'd0);
            chk($sformatf("R1 rsp v%0d", i), int'(rsp_valid), 1);
            chk($sformatf("R7 accept v%0d", i), int'(rsp_accept), int'(TBL[i].acc));
            chk($sformatf("R7 cause v%0d", i), int'(rsp_cause), int'(TBL[i].cause));
            chk($sformatf("R8 slot v%0d", i), int'(rsp_slot), int'(TBL[i].slot));
            chk($sformatf("R3 warps v%0d", i), int'(occ_warps), int'(TBL[i].warps));
            chk($sformatf("R6 regs v%0d", i), int'(res_regs), int'(TBL[i].regs));
         end
      end

      // R3 R4 R8: thirty-two 32-thread blocks
      for (int i = 0; i < 32; i++) begin
         drive(1'b1, 11'd32, 8'd2, 1'b0, 5'd0);
         chk("R8 fill slot", int'(rsp_slot), i);
         chk("R3 fill warps", int'(occ_warps), i + 1);
      end
      chk("R4 blocks full", int'(res_blocks), 32);
      chk("R5 threads", int'(res_threads), 1024);
      drive(1'b1, 11'd32, 8'd2, 1'b0, 5'd0);
      chk("R4 reject", int'(rsp_accept), 0);
      chk("R4 cause", int'(rsp_cause), 2);
      drive(1'b1, 11'd2000, 8'd2, 1'b0, 5'd0);
      chk("R7 bad size first", int'(rsp_cause), 1);

      // R9 R10: release then stray release
      drive(1'b0, 11'd0, 8'd0, 1'b1, 5'd5);
      chk("R9 warps", int'(occ_warps), 31);
      chk("R10 no err", int'(err_release), 0);
      drive(1'b0, 11'd0, 8'd0, 1'b1, 5'd5);
      chk("R10 err", int'(err_release), 1);
      chk("R10 warps kept", int'(occ_warps), 31);
      chk("R10 regs kept", int'(res_regs), 31 * 64);
      @(posedge clk); @(negedge clk);
      chk("R10 err one cycle", int'(err_release), 0);

      // R8 R9: freed slot reused
      drive(1'b1, 11'd32, 8'd2, 1'b0, 5'd0);
      chk("R9 reuse accept", int'(rsp_accept), 1);
      chk("R8 reuse slot", int'(rsp_slot), 5);

      // R11: request and release together while full
      drive(1'b1, 11'd32, 8'd2, 1'b1, 5'd6);
      chk("R11 reject", int'(rsp_accept), 0);
      chk("R11 cause", int'(rsp_cause), 2);
      chk("R11 blocks", int'(res_blocks), 31);
      chk("R11 warps", int'(occ_warps), 31);
      drive(1'b1, 11'd32, 8'd2, 1'b0, 5'd0);
      chk("R11 then accept", int'(rsp_accept), 1);
      chk("R11 slot", int'(rsp_slot), 6);

      summary();
   end
endmodule